// File: doc/BRIEF.md
# Buffered Synchronous Serial Port

This block is a clocked synchronous serial channel. It has a shift clock, a serial data output, a serial data input and an active-low chip select. A local byte buffer backs the channel, so the host can move a whole block of bytes with no service per byte. The host fills the buffer through a plain RAM write port, picks a buffer arrangement and a clock source, and gives a byte count and a one-cycle start pulse. The block then streams bytes out MSB first and stores each received byte. When the count runs out it raises a done flag, and it holds busy for a short cool-down before it accepts the next start. Received data is read back through the same RAM port.

The buffer has two arrangements. In shared arrangement it is one transfer area, and each received byte replaces the transmitted byte at the same location. In split arrangement the lower half supplies transmit bytes and the upper half collects received bytes. The shift clock comes from one of two sources. The block can make it internally from the peripheral clock and drive it out, or it can take it from an external master. In the external case chip select gates the incoming clock and the serial output is released while chip select is high. The buffer ports are plain RAM ports with no valid/ready handshake, so they have no back-pressure. A start pulse that arrives while busy is high is dropped.

Top module: `bsp_port`

## Requirements
- R1: After reset, busy and done are 0, the internal shift clock output idles at 1, the serial output is 1 and the output enable is 1 (internal-clock mode).
- R2: In internal-clock mode every low phase of the shift clock lasts exactly HALF_PER (4) peripheral clocks and every high phase lasts at least HALF_PER. The clock sits at 1 whenever busy is 0.
- R3: Each byte is sent MSB first (bit 7 first). The serial output takes its new bit on a falling edge of the shift clock, and the receiver reads it while the clock is high. This holds in both clock modes.
- R4: The serial input is sampled on each rising shift-clock edge, and 8 samples form a byte, MSB first. In shared arrangement (split_mode=0), byte k is sent from buffer address k and the received byte k is written back to address k.
- R5: In split arrangement (split_mode=1), byte k is sent from address k and received into address DEPTH/2+k. The lower half is left unchanged.
- R6: The number of bytes moved is the requested count clamped to DEPTH (shared) or DEPTH/2 (split). A count of 0 moves no bytes and produces no shift clock edges, but done is still raised.
- R7: done goes to 1 when the last byte has been stored. It goes to 0 in the cycle after a start is accepted.
- R8: After done rises, busy stays 1 for exactly COOL (6) peripheral clocks. A start pulse during that window is ignored, and done stays 1.
- R9: In external-clock mode with cs_n_i high, the output enable is 0 and edges on sck_i have no effect on the transfer.
- R10: In external-clock mode, edges on sck_i in the first MASK (3) clocks after the synchronized chip select goes low are ignored.
- R11: The host read port returns mem[host_raddr] one clock after the address is presented. A host write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Buffer write enable |
| host_waddr | input | $clog2(DEPTH) | Buffer write address |
| host_wdata | input | 8 | Buffer write data |
| host_raddr | input | $clog2(DEPTH) | Buffer read address |
| host_rdata | output | 8 | Registered buffer read data |
| start | input | 1 | One-cycle transfer start |
| split_mode | input | 1 | 1 = separate transmit/receive halves, 0 = shared area |
| ext_clk | input | 1 | 1 = shift clock from sck_i, 0 = internal |
| byte_count | input | CNT_W | Requested number of bytes |
| busy | output | 1 | Transfer or cool-down in progress |
| done | output | 1 | Last transfer completed |
| sck_o | output | 1 | Internally generated shift clock |
| sck_i | input | 1 | External shift clock |
| cs_n_i | input | 1 | Active-low chip select for external-clock mode |
| si_i | input | 1 | Serial data input |
| so_o | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for so_o (0 = high impedance) |

## Verification
The case hardest to reach from the ports is a stray shift-clock edge that lands inside the mask window right after chip select goes active. Such an edge would silently add one bit and shift every later received byte. To reach it, the bench lowers chip select and sck_i in the same cycle and raises sck_i again one cycle later, so both edges fall inside the window. It then clocks a full block and compares the stored bytes and each transmitted bit with values it computes from a seed. The internal-clock sweep covers every count from 0 to past the capacity of both arrangements, and a start pulse is injected in the middle of each cool-down.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_STORE,
    ST_COOL
  } eng_state_t;
endpackage

// File: rtl/bsp_buf.sv
module bsp_buf #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_waddr_i,
  input  logic [7:0]    host_wdata_i,
  input  logic [AW-1:0] host_raddr_i,
  output logic [7:0]    host_rdata_o,
  input  logic [AW-1:0] tx_addr_i,
  output logic [7:0]    tx_data_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [7:0]    eng_wdata_i
);
  logic [7:0] mem_q [DEPTH];

  // engine write wins a same-cycle collision with the host
  always_ff @(posedge clk) begin
    if (eng_we_i) begin
      mem_q[eng_addr_i] <= eng_wdata_i;
    end else if (host_we_i) begin
      mem_q[host_waddr_i] <= host_wdata_i;
    end
    host_rdata_o <= mem_q[host_raddr_i];
  end

  assign tx_data_o = mem_q[tx_addr_i];
endmodule

// File: rtl/bsp_sck_gen.sv
module bsp_sck_gen #(
  parameter int HALF_PER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic sck_o,
  output logic fall_o,
  output logic rise_o,
  output logic end_o
);
  localparam int PW = $clog2(2 * HALF_PER);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (cnt_q == PW'(2 * HALF_PER - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fall_o = en_i && (cnt_q == '0);
  assign rise_o = en_i && (cnt_q == PW'(HALF_PER));
  assign end_o  = en_i && (cnt_q == PW'(2 * HALF_PER - 1));
  assign sck_o  = !(en_i && (cnt_q < PW'(HALF_PER)));
endmodule

// File: rtl/bsp_cs_front.sv
module bsp_cs_front #(
  parameter int MASK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int MW = $clog2(MASK + 1);

  logic          sck_m, sck_s, sck_d;
  logic          cs_m, cs_s, cs_d;
  logic [MW-1:0] mask_q;
  logic          cs_edge;
  logic          open_gate;

  assign cs_edge   = cs_d && !cs_s;
  assign open_gate = !cs_s && !cs_edge && (mask_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m  <= 1'b1;
      sck_s  <= 1'b1;
      sck_d  <= 1'b1;
      cs_m   <= 1'b1;
      cs_s   <= 1'b1;
      cs_d   <= 1'b1;
      mask_q <= '0;
    end else begin
      sck_m <= sck_i;
      sck_s <= sck_m;
      sck_d <= sck_s;
      cs_m  <= cs_n_i;
      cs_s  <= cs_m;
      cs_d  <= cs_s;
      if (cs_edge) begin
        mask_q <= MW'(MASK - 1);
      end else if (mask_q != '0) begin
        mask_q <= mask_q - 1'b1;
      end
    end
  end

  assign fall_o = open_gate && sck_d && !sck_s;
  assign rise_o = open_gate && !sck_d && sck_s;

  assert_cs_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !(rise_o || fall_o));
  assert_mask_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && !cs_s) |-> !(rise_o || fall_o));
  assert_mask_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && !cs_s) |=> !(rise_o || fall_o));
endmodule

// File: rtl/bsp_engine.sv
module bsp_engine
  import bsp_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int COOL  = 6,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             split_i,
  input  logic             ext_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic             end_i,
  input  logic             si_i,
  input  logic [7:0]       tx_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             gen_en_o,
  output logic             ext_o,
  output logic             so_o,
  output logic [AW-1:0]    tx_addr_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [7:0]       wr_data_o
);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int KW     = $clog2(COOL + 1);
  localparam int HALF_D = DEPTH / 2;

  eng_state_t    state_q;
  logic          split_q, ext_q, done_q, so_q;
  logic [CW-1:0] rem_q;
  logic [AW-1:0] idx_q;
  logic [7:0]    sreg_q;
  logic [3:0]    bitcnt_q;
  logic [KW-1:0] cool_q;
  logic [CW-1:0] cap;
  logic [CW-1:0] first_rem;

  assign cap       = split_i ? CW'(HALF_D) : CW'(DEPTH);
  assign first_rem = (count_i > CNT_W'(cap)) ? cap : CW'(count_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      split_q  <= 1'b0;
      ext_q    <= 1'b0;
      done_q   <= 1'b0;
      so_q     <= 1'b1;
      rem_q    <= '0;
      idx_q    <= '0;
      sreg_q   <= '0;
      bitcnt_q <= '0;
      cool_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            split_q <= split_i;
            ext_q   <= ext_i;
            rem_q   <= first_rem;
            idx_q   <= '0;
            done_q  <= 1'b0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            cool_q  <= KW'(COOL - 1);
            state_q <= ST_COOL;
          end else begin
            sreg_q   <= tx_data_i;
            bitcnt_q <= '0;
            state_q  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (fall_i) begin
            so_q <= sreg_q[7];
          end
          if (rise_i) begin
            sreg_q   <= {sreg_q[6:0], si_i};
            bitcnt_q <= bitcnt_q + 1'b1;
          end
          if ((bitcnt_q == 4'd8) && (ext_q || end_i)) begin
            state_q <= ST_STORE;
          end
        end
        ST_STORE: begin
          idx_q   <= idx_q + 1'b1;
          rem_q   <= rem_q - 1'b1;
          state_q <= ST_LOAD;
        end
        ST_COOL: begin
          if (cool_q == '0) begin
            state_q <= ST_IDLE;
          end else begin
            cool_q <= cool_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign gen_en_o  = (state_q == ST_SHIFT) && !ext_q;
  assign ext_o     = ext_q;
  assign so_o      = so_q;
  assign tx_addr_o = idx_q;
  assign wr_en_o   = (state_q == ST_STORE);
  assign wr_addr_o = split_q ? (idx_q + AW'(HALF_D)) : idx_q;
  assign wr_data_o = sreg_q;

  assert_store_full_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE) |-> (bitcnt_q == 4'd8));
  assert_split_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (split_q && state_q != ST_IDLE) |-> (rem_q <= CW'(HALF_D)));
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> !done_q);
  assert_done_enters_cool_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (state_q == ST_COOL));
  assert_cool_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COOL && start_i) |=> done_q);
endmodule

// File: rtl/bsp_port.sv
module bsp_port #(
  parameter int DEPTH    = 128,
  parameter int HALF_PER = 4,
  parameter int COOL     = 6,
  parameter int MASK     = 3,
  parameter int CNT_W    = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [AW-1:0]    host_waddr,
  input  logic [7:0]       host_wdata,
  input  logic [AW-1:0]    host_raddr,
  output logic [7:0]       host_rdata,
  input  logic             start,
  input  logic             split_mode,
  input  logic             ext_clk,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             done,
  output logic             sck_o,
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic             si_i,
  output logic             so_o,
  output logic             so_oe
);
  logic          gen_en, ext_q;
  logic          m_fall, m_rise, m_end;
  logic          s_fall, s_rise;
  logic          fall, rise;
  logic [AW-1:0] tx_addr, wr_addr;
  logic [7:0]    tx_data, wr_data;
  logic          wr_en;

  bsp_buf #(.DEPTH(DEPTH)) u_buf (
    .clk          (clk),
    .host_we_i    (host_we),
    .host_waddr_i (host_waddr),
    .host_wdata_i (host_wdata),
    .host_raddr_i (host_raddr),
    .host_rdata_o (host_rdata),
    .tx_addr_i    (tx_addr),
    .tx_data_o    (tx_data),
    .eng_we_i     (wr_en),
    .eng_addr_i   (wr_addr),
    .eng_wdata_i  (wr_data)
  );

  bsp_sck_gen #(.HALF_PER(HALF_PER)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (gen_en),
    .sck_o  (sck_o),
    .fall_o (m_fall),
    .rise_o (m_rise),
    .end_o  (m_end)
  );

  bsp_cs_front #(.MASK(MASK)) u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_i  (sck_i),
    .cs_n_i (cs_n_i),
    .fall_o (s_fall),
    .rise_o (s_rise)
  );

  assign fall = ext_q ? s_fall : m_fall;
  assign rise = ext_q ? s_rise : m_rise;

  bsp_engine #(.DEPTH(DEPTH), .COOL(COOL), .CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .split_i   (split_mode),
    .ext_i     (ext_clk),
    .count_i   (byte_count),
    .fall_i    (fall),
    .rise_i    (rise),
    .end_i     (m_end),
    .si_i      (si_i),
    .tx_data_i (tx_data),
    .busy_o    (busy),
    .done_o    (done),
    .gen_en_o  (gen_en),
    .ext_o     (ext_q),
    .so_o      (so_o),
    .tx_addr_o (tx_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  assign so_oe = ext_q ? !cs_n_i : 1'b1;

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_o);
  assert_low_phase_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |=> !sck_o);
  assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
endmodule

// File: tb/bsp_port_bench.sv
module bsp_port_bench;
  localparam int DEPTH = 16, H = DEPTH / 2, HALF_PER = 4, COOL = 6, MASK = 3;
  localparam int CNT_W = 8, AW = $clog2(DEPTH), LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic host_we = 0, start = 0, split_mode = 0, ext_clk = 0;
  logic [AW-1:0] host_waddr = '0, host_raddr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [CNT_W-1:0] byte_count = '0;
  logic busy, done, sck_o, so_o, so_oe, si_i;
  logic sck_i = 1'b1, cs_n_i = 1'b1, s_si = 1'b0, slave_run = 1'b0;

  int total = 0, bad = 0, cyc = 0;

  // responder state (internal-clock mode)
  logic prev_sck = 1'b1, m_si = 1'b0, resp_clr = 1'b0;
  int fall_n = 0, rise_n = 0, low_len = 0, high_len = 0, phase_bad = 0, r_seed = 0;
  logic [7:0] cap_tx [DEPTH];

  assign si_i = slave_run ? s_si : m_si;

  bsp_port #(.DEPTH(DEPTH), .HALF_PER(HALF_PER), .COOL(COOL), .MASK(MASK), .CNT_W(CNT_W)) u_bsp_port (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .start(start), .split_mode(split_mode), .ext_clk(ext_clk), .byte_count(byte_count),
    .busy(busy), .done(done), .sck_o(sck_o), .sck_i(sck_i), .cs_n_i(cs_n_i),
    .si_i(si_i), .so_o(so_o), .so_oe(so_oe)
  );

  function automatic logic [7:0] init_b(int i, int seed);
    return 8'((i * 53 + 7 + seed * 11) & 255);
  endfunction
  function automatic logic [7:0] sdat(int i, int seed);
    return 8'((i * 37 + 91 + seed * 29) & 255);
  endfunction
  function automatic logic [7:0] exp_mem(int a, bit split, int n, int seed);
    if (!split) return (a < n) ? sdat(a, seed) : init_b(a, seed);
    if (a < H) return init_b(a, seed);
    return ((a - H) < n) ? sdat(a - H, seed) : init_b(a, seed);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (resp_clr) begin
      fall_n = 0; rise_n = 0; low_len = 0; high_len = 0; phase_bad = 0;
    end else if (prev_sck && !sck_o) begin
      logic [7:0] b;
      if (rise_n > 0 && high_len < HALF_PER) phase_bad++;
      b = sdat(fall_n / 8, r_seed);
      m_si = b[7 - fall_n % 8];
      fall_n++;
      low_len = 1;
    end else if (!prev_sck && sck_o) begin
      if (low_len != HALF_PER) phase_bad++;
      cap_tx[rise_n / 8][7 - rise_n % 8] = so_o;
      rise_n++;
      high_len = 1;
    end else if (!sck_o) begin
      low_len++;
    end else begin
      high_len++;
    end
    prev_sck = sck_o;
  end

  task automatic fill(int seed);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      host_we = 1; host_waddr = AW'(i); host_wdata = init_b(i, seed);
    end
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    host_raddr = AW'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic check_mem(bit split, int n, int seed);
    logic [7:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, d);
      check(d == exp_mem(a, split, n, seed), split ? "R5" : "R4", "buffer byte", d, exp_mem(a, split, n, seed));
    end
  endtask

  task automatic pulse_start(bit split, bit ext, int count);
    @(negedge clk);
    start = 1; split_mode = split; ext_clk = ext; byte_count = CNT_W'(count);
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
    check(done == 1'b0, "R7", "done cleared by start", done, 0);
  endtask

  task automatic run_master(bit split, int count, int seed);
    int n, k;
    n = (count > (split ? H : DEPTH)) ? (split ? H : DEPTH) : count;
    fill(seed);
    r_seed = seed;
    resp_clr = 1; @(negedge clk); @(negedge clk); resp_clr = 0;
    pulse_start(split, 1'b0, count);
    while (!done) @(negedge clk);
    k = 0;
    while (busy) begin
      k++;
      start = (k == 3);
      @(negedge clk);
    end
    start = 0;
    check(k == COOL, "R8", "cool-down length", k, COOL);
    check(done == 1'b1, "R8", "done kept after start in cool-down", done, 1);
    check(fall_n == 8 * n, "R6", "shift clock edges", fall_n, 8 * n);
    check(phase_bad == 0, "R2", "clock phase violations", phase_bad, 0);
    for (int i = 0; i < n; i++)
      check(cap_tx[i] == init_b(i, seed), "R3", "transmitted byte", cap_tx[i], init_b(i, seed));
    check_mem(split, n, seed);
  endtask

  task automatic run_slave(bit split, int count, int seed, bit glitch);
    int n;
    logic [7:0] got, want;
    n = (count > (split ? H : DEPTH)) ? (split ? H : DEPTH) : count;
    fill(seed);
    slave_run = 1; cs_n_i = 1; sck_i = 1;
    pulse_start(split, 1'b1, count);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); sck_i = ~sck_i;
      repeat (4) @(negedge clk);
    end
    sck_i = 1;
    check(so_oe == 1'b0, "R9", "output enable with chip select high", so_oe, 0);
    repeat (6) @(negedge clk);
    check(busy == 1'b1 && done == 1'b0, "R9", "transfer untouched by masked clock", done, 0);
    @(negedge clk);
    cs_n_i = 0;
    if (glitch) begin
      sck_i = 0;
      @(negedge clk);
      sck_i = 1;
    end
    repeat (8) @(negedge clk);
    check(so_oe == 1'b1, "R9", "output enable with chip select low", so_oe, 1);
    for (int i = 0; i < n; i++) begin
      want = init_b(i, seed);
      got = '0;
      for (int b = 7; b >= 0; b--) begin
        logic [7:0] sd;
        sd = sdat(i, seed);
        @(negedge clk);
        sck_i = 0; s_si = sd[b];
        repeat (7) @(negedge clk);
        got[b] = so_o;
        @(negedge clk);
        sck_i = 1;
        repeat (7) @(negedge clk);
      end
      check(got == want, glitch ? "R10" : "R3", "slave transmitted byte", got, want);
    end
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R7", "done after last slave byte", done, 1);
    cs_n_i = 1;
    while (busy) @(negedge clk);
    check_mem(split, n, seed);
    slave_run = 0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    check(sck_o == 1'b1 && so_o == 1'b1, "R1", "idle clock/data", {sck_o, so_o}, 3);
    check(so_oe == 1'b1, "R1", "output enable after reset", so_oe, 1);
    @(negedge clk);
    host_we = 1; host_waddr = AW'(5); host_wdata = 8'hA5;
    @(negedge clk);
    host_we = 0;
    rd(5, d);
    check(d == 8'hA5, "R11", "host read after write", d, 8'hA5);
    for (int sp = 0; sp < 2; sp++)
      for (int c = 0; c <= (sp ? H : DEPTH) + 2; c++)
        run_master(sp[0], c, c + sp * 5);
    run_slave(1'b0, 3, 1, 1'b0);
    run_slave(1'b0, 4, 2, 1'b1);
    run_slave(1'b1, 20, 3, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule